// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block holds the per-line state of a small nested interrupt controller. For each of `N` interrupt inputs it keeps a Pending bit and an Active bit. Raw input levels are brought into the clock domain through a two-flop synchroniser and compared with their value from the previous cycle to find rising edges. Software-style mask writes can set or clear Pending. An acknowledge strobe with an index moves one interrupt into the Active state. A complete strobe with an index takes it out again.

Pending combines level and edge behaviour. A rising edge always pends the line. An interrupt that completes while its line is still high pends again in the same update. A clear request cannot drop Pending while the line is held high and the interrupt is not active, so a level request that is still asserted is never lost. A fixed-priority selector reports the lowest-numbered interrupt that is pending and not active, for use by the exception-entry logic outside this block.

Top module: `irq_state_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every Pending bit, every Active bit and the edge-detect history, and `sel_valid` reads 0 while reset is held.
- R2: A low-to-high change on `irq_in[i]` sets Pending for line i whether or not the line is Active. The new Pending value is visible after the third rising clock edge that follows the input change: two synchroniser flops, then the state register.
- R3: A completion of an Active interrupt clears Active. If the synchronised line is high at that edge, Pending is set in the same update. If the line is low, Pending stays 0.
- R4: A clear request (`clr_pend_we` with mask bit i set) clears Pending i when line i is low or Active i is 1. It has no effect while line i is high and Active i is 0.
- R5: An acknowledge for index i sets Active i and clears Pending i in the same update, even while line i is high.
- R6: When line i falls while Pending i is 1, Pending i stays 1.
- R7: While Active i is 1 and line i stays high with no new rising edge, Pending i stays 0.
- R8: A set request (`set_pend_we` with mask bit i set) sets Pending i unconditionally. When a set and a clear request hit the same bit in the same cycle, the set wins.
- R9: A completion strobe whose index names an interrupt that is not Active changes neither Pending nor Active.
- R10: `sel_valid` is 1 exactly when some line is Pending and not Active. `sel_idx` then gives the lowest such line number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | N | Raw interrupt request levels, one per line |
| set_pend_we | input | 1 | Strobe for the set-pending mask |
| set_pend_mask | input | N | One bit per line to set Pending |
| clr_pend_we | input | 1 | Strobe for the clear-pending mask |
| clr_pend_mask | input | N | One bit per line to clear Pending |
| ack_valid | input | 1 | Single-cycle acknowledge strobe |
| ack_idx | input | $clog2(N) | Line number being acknowledged |
| cmp_valid | input | 1 | Single-cycle completion strobe |
| cmp_idx | input | $clog2(N) | Line number being completed |
| pend_o | output | N | Pending vector |
| actv_o | output | N | Active vector |
| sel_valid | output | 1 | A pending, non-active line exists |
| sel_idx | output | $clog2(N) | Lowest-numbered pending, non-active line |

## Verification
The bench drives one line through the sequence raise, clear attempt, acknowledge, completion while held high, and a second acknowledge with the line dropped before completion. This separates the ongoing-level rule from the edge rule and from the re-pend on completion. Further patterns raise a line while it is already Active, drop a line that is pending, send a completion to an idle line, and issue set and clear to the same bit in one cycle. These show that each source of Pending acts alone and that the precedence is right. Multi-bit set masks with successive acknowledges move the selector across several candidates, and a final mid-run reset shows that all state and history are cleared.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

  typedef struct packed {
    logic pend;
    logic act;
  } line_state_t;

  // Next state of one line. Sources that set Pending win over every clear.
  function automatic line_state_t line_next(
    input line_state_t cur,
    input logic        rise,
    input logic        lvl,
    input logic        set_req,
    input logic        clr_req,
    input logic        ack,
    input logic        cmp
  );
    line_state_t nx;
    logic fall_act;
    logic clr_ok;
    logic set_src;
    fall_act = cur.act & cmp & ~ack;
    clr_ok   = clr_req & ~(lvl & ~cur.act);
    set_src  = rise | set_req | (fall_act & lvl);
    nx.act   = ack | (cur.act & ~cmp);
    nx.pend  = set_src | (cur.pend & ~clr_ok & ~ack);
    return nx;
  endfunction

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [STAGES-1:0][N-1:0] chain_q;
  logic [N-1:0]             prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= '0;
          else     chain_q[0] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_trk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic lvl_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  input  logic cmp_i,
  output logic pend_o,
  output logic act_o,
  output logic repend_o
);
  line_state_t st_q;
  line_state_t st_d;

  always_comb st_d = line_next(st_q, rise_i, lvl_i, set_i, clr_i, ack_i, cmp_i);

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign pend_o   = st_q.pend;
  assign act_o    = st_q.act;
  assign repend_o = st_q.act & cmp_i & ~ack_i & lvl_i;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = IW'(i);
    end
    valid_o = |cand_i;
  end
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          set_pend_we,
  input  logic [N-1:0]  set_pend_mask,
  input  logic          clr_pend_we,
  input  logic [N-1:0]  clr_pend_mask,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  input  logic          cmp_valid,
  input  logic [IW-1:0] cmp_idx,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  actv_o,
  output logic          sel_valid,
  output logic [IW-1:0] sel_idx
);
  logic [N-1:0] lvl_sync;
  logic [N-1:0] rise_vec;
  logic [N-1:0] ack_dec;
  logic [N-1:0] cmp_dec;
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] repend_vec;

  irq_sync_edge #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (irq_in),
    .lvl_o  (lvl_sync),
    .rise_o (rise_vec)
  );

  assign set_vec = set_pend_we ? set_pend_mask : '0;
  assign clr_vec = clr_pend_we ? clr_pend_mask : '0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      assign ack_dec[i] = ack_valid && (ack_idx == IW'(i));
      assign cmp_dec[i] = cmp_valid && (cmp_idx == IW'(i));
      irq_line_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (rise_vec[i]),
        .lvl_i    (lvl_sync[i]),
        .set_i    (set_vec[i]),
        .clr_i    (clr_vec[i]),
        .ack_i    (ack_dec[i]),
        .cmp_i    (cmp_dec[i]),
        .pend_o   (pend_o[i]),
        .act_o    (actv_o[i]),
        .repend_o (repend_vec[i])
      );
    end
  endgenerate

  irq_pick #(.N(N), .IW(IW)) u_pick (
    .cand_i  (pend_o & ~actv_o),
    .valid_o (sel_valid),
    .idx_o   (sel_idx)
  );
endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_pend_we,
  input logic [N-1:0]  clr_pend_mask,
  input logic          ack_valid,
  input logic [IW-1:0] ack_idx,
  input logic          cmp_valid,
  input logic [IW-1:0] cmp_idx,
  input logic [N-1:0]  lvl_sync,
  input logic [N-1:0]  rise_vec,
  input logic [N-1:0]  repend_vec,
  input logic [N-1:0]  pend_o,
  input logic [N-1:0]  actv_o,
  input logic          sel_valid,
  input logic [IW-1:0] sel_idx
);
  a_r2_rise_pends: assert property (@(posedge clk) disable iff (rst)
    (|rise_vec) |=> ((pend_o & $past(rise_vec)) == $past(rise_vec)));

  a_r3_repend_on_complete: assert property (@(posedge clk) disable iff (rst)
    (|repend_vec) |=> ((pend_o & $past(repend_vec)) == $past(repend_vec)));

  a_r4_held_line_keeps_pend: assert property (@(posedge clk) disable iff (rst)
    (clr_pend_we && !ack_valid && |(clr_pend_mask & lvl_sync & ~actv_o & pend_o))
    |=> ((pend_o & $past(clr_pend_mask & lvl_sync & ~actv_o & pend_o))
         == $past(clr_pend_mask & lvl_sync & ~actv_o & pend_o)));

  a_r5_ack_activates: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> actv_o[$past(ack_idx)]);

  a_r9_idle_complete_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !actv_o[cmp_idx] && !(ack_valid && ack_idx == cmp_idx))
    |=> !actv_o[$past(cmp_idx)]);

  a_r10_sel_is_candidate: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (pend_o[sel_idx] && !actv_o[sel_idx]));

  a_r10_sel_none: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |-> ((pend_o & ~actv_o) == '0));
endmodule

bind irq_state_tracker irq_state_tracker_chk #(.N(N), .IW(IW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .clr_pend_we   (clr_pend_we),
  .clr_pend_mask (clr_pend_mask),
  .ack_valid     (ack_valid),
  .ack_idx       (ack_idx),
  .cmp_valid     (cmp_valid),
  .cmp_idx       (cmp_idx),
  .lvl_sync      (lvl_sync),
  .rise_vec      (rise_vec),
  .repend_vec    (repend_vec),
  .pend_o        (pend_o),
  .actv_o        (actv_o),
  .sel_valid     (sel_valid),
  .sel_idx       (sel_idx)
);

// File: tb/tb_irq_state_tracker.sv
`timescale 1ns/1ps
module tb_irq_state_tracker;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  irq_in;
  logic          set_pend_we;
  logic [N-1:0]  set_pend_mask;
  logic          clr_pend_we;
  logic [N-1:0]  clr_pend_mask;
  logic          ack_valid;
  logic [IW-1:0] ack_idx;
  logic          cmp_valid;
  logic [IW-1:0] cmp_idx;
  logic [N-1:0]  pend_o;
  logic [N-1:0]  actv_o;
  logic          sel_valid;
  logic [IW-1:0] sel_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [2*N-1:0] qv[$];
  string          qt[$];

  always #2 clk = ~clk;

  irq_state_tracker #(.N(N)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .set_pend_we(set_pend_we), .set_pend_mask(set_pend_mask),
    .clr_pend_we(clr_pend_we), .clr_pend_mask(clr_pend_mask),
    .ack_valid(ack_valid), .ack_idx(ack_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .pend_o(pend_o), .actv_o(actv_o),
    .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  // Monitor: pops one expected item per cycle, samples 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (qv.size() > 0) begin
      logic [2*N-1:0] e;
      string          tag;
      logic [N-1:0]   ep, ea, cand;
      logic           ev;
      logic [IW-1:0]  ei;
      e   = qv.pop_front();
      tag = qt.pop_front();
      ep  = e[2*N-1:N];
      ea  = e[N-1:0];
      cand = ep & ~ea;
      ev = 1'b0;
      ei = '0;
      for (int k = 0; k < N; k++) begin
        if (!ev && cand[k]) begin
          ev = 1'b1;
          ei = IW'(k);
        end
      end
      checks++;
      if (pend_o !== ep || actv_o !== ea || sel_valid !== ev || (ev && sel_idx !== ei)) begin
        errors++;
        $display("FAIL %s: pend=%h act=%h selv=%b sel=%0d expected pend=%h act=%h selv=%b sel=%0d",
                 tag, pend_o, actv_o, sel_valid, sel_idx, ep, ea, ev, ei);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input string tag, input logic [N-1:0] p, input logic [N-1:0] a);
    qv.push_back({p, a});
    qt.push_back(tag);
    tick(1);
  endtask

  task automatic drive_line(input int i, input logic v);
    irq_in[i] = v;
    tick(4);
  endtask

  task automatic do_ack(input int i);
    ack_valid = 1'b1; ack_idx = IW'(i);
    tick(1);
    ack_valid = 1'b0;
    tick(1);
  endtask

  task automatic do_cmp(input int i);
    cmp_valid = 1'b1; cmp_idx = IW'(i);
    tick(1);
    cmp_valid = 1'b0;
    tick(1);
  endtask

  task automatic do_write(input logic s, input logic [N-1:0] sm, input logic c, input logic [N-1:0] cm);
    set_pend_we = s; set_pend_mask = sm;
    clr_pend_we = c; clr_pend_mask = cm;
    tick(1);
    set_pend_we = 1'b0; clr_pend_we = 1'b0;
    tick(1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_in = '0;
    set_pend_we = 0; set_pend_mask = '0; clr_pend_we = 0; clr_pend_mask = '0;
    ack_valid = 0; ack_idx = '0; cmp_valid = 0; cmp_idx = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    expect_st("R1 after reset", 8'h00, 8'h00);

    drive_line(2, 1'b1);
    expect_st("R2 rise pends line 2", 8'h04, 8'h00);
    do_write(0, '0, 1, 8'h04);
    expect_st("R4 clear ignored, line high idle", 8'h04, 8'h00);
    do_ack(2);
    expect_st("R5 ack clears pend while line high", 8'h00, 8'h04);
    tick(5);
    expect_st("R7 held high while active", 8'h00, 8'h04);
    do_write(1, 8'h04, 0, '0);
    expect_st("R8 set pend on active line", 8'h04, 8'h04);
    do_write(0, '0, 1, 8'h04);
    expect_st("R4 clear allowed while active", 8'h00, 8'h04);
    do_cmp(2);
    expect_st("R3 complete with line high re-pends", 8'h04, 8'h00);

    do_ack(2);
    drive_line(2, 1'b0);
    expect_st("R5 ack then line low", 8'h00, 8'h04);
    do_cmp(2);
    expect_st("R3 complete with line low", 8'h00, 8'h00);

    drive_line(5, 1'b1);
    expect_st("R2 rise pends line 5", 8'h20, 8'h00);
    drive_line(5, 1'b0);
    expect_st("R6 fall keeps pend", 8'h20, 8'h00);
    do_ack(5);
    drive_line(5, 1'b1);
    expect_st("R2 rise pends active line", 8'h20, 8'h20);
    expect_st("R10 only active lines pending", 8'h20, 8'h20);
    do_cmp(3);
    expect_st("R9 complete on idle line ignored", 8'h20, 8'h20);
    do_write(0, '0, 1, 8'h20);
    expect_st("R4 clear allowed active high", 8'h00, 8'h20);

    do_write(1, 8'h02, 1, 8'h02);
    expect_st("R8 set beats clear", 8'h02, 8'h20);
    do_write(0, '0, 1, 8'h02);
    expect_st("R4 clear allowed line low", 8'h00, 8'h20);

    do_write(1, 8'hC8, 0, '0);
    expect_st("R10 lowest of three", 8'hC8, 8'h20);
    do_ack(3);
    expect_st("R10 next after ack", 8'hC0, 8'h28);
    do_cmp(5);
    expect_st("R3 re-pend moves selector", 8'hE0, 8'h08);

    irq_in[0] = 1'b1; irq_in[7] = 1'b1;
    tick(4);
    expect_st("R2 two lines rise together", 8'hE1, 8'h08);

    rst = 1'b1;
    tick(2);
    expect_st("R1 mid-run reset", 8'h00, 8'h00);
    rst = 1'b0;
    tick(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule